// File: doc/BRIEF.md
# Coprocessor Bus Arbitration and Bank Control

This block sits between the main processor's byte/word access port and a sound coprocessor. It holds the flag that starts or halts the coprocessor, generates a one-clock reset pulse for it, and keeps a 9-bit bank value. The bank value picks which 32 KB window of main memory the coprocessor can see. It also decides whether host writes reach the coprocessor's 8 KB work RAM. Those writes go through only while the coprocessor is halted, which means the host holds its bus.

Host accesses arrive as valid/ready requests carrying a 24-bit address, a write flag, a word/byte flag and 16 bits of write data. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Every accepted read returns exactly one response on a valid/ready response channel, and writes return nothing. Only one read response is held at a time, so `req_ready` equals `!rsp_valid || rsp_ready`. While a response is stalled, no request of any kind is accepted, and the response data stays unchanged.

The work RAM is outside the block. It is a synchronous RAM with a read latency of one clock, and its output must hold its last value while `ram_re` is low. Reads of the bus-request location report whether the bus is still busy. A halt is not shown as complete until a short grant delay after the halt write has passed.

Top module: `copro_bus_ctrl`

## Requirements
- R1: An accepted write to address 0xA11100 sets `copro_run` to the inverse of bit 0 of the write byte from the next clock on. The write byte is `req_wdata[7:0]` for byte writes and `req_wdata[15:8]` for word writes.
- R2: A read of 0xA11100 returns the status byte {1, 000000, busy} in both halves of `rsp_data`. This holds for byte and word reads alike.
- R3: busy is 1 when `copro_run` is 1. Let T be the clock of an accepted write that drops `copro_run` from 1 to 0. busy is also 1 for a read accepted at T+k with 1 ≤ k ≤ 32, and 0 for k ≥ 33 while the coprocessor stays halted.
- R4: An accepted write to 0xA11200 whose write byte has bit 0 clear drives `copro_rst` high for exactly the clock after acceptance. If that bit is set, no pulse is produced.
- R5: Any write whose address satisfies (addr & 0xFF7F00) == 0xA06000 shifts `bank` right by one and places `req_wdata[0]` in bit 8. Writes at other addresses leave `bank` unchanged.
- R6: A write with (addr & 0xFF4000) == 0xA00000 raises `ram_we` in its acceptance clock, with `ram_addr` = addr[12:0] and `ram_wdata` = the write byte (the high byte for word writes). This happens only while `copro_run` is 0. Otherwise the write is dropped.
- R7: A read in the RAM window raises `ram_re` in its acceptance clock. Its response is {`ram_rdata`, `ram_rdata`}, taken from the RAM output one clock later.
- R8: Reads at any other address, including the rest of 0xA00000–0xA0FFFF and 0xA11200, return 0xFFFF.
- R9: After reset, `copro_run` = 1, `bank` = 0, `copro_rst` = 0 and `rsp_valid` = 0.
- R10: Each accepted read gives exactly one response, in order, and writes give none. A response held while `rsp_ready` is low keeps `rsp_valid` high and `rsp_data` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 24 | Host byte address |
| req_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response this clock |
| rsp_data | output | 16 | Read response data |
| copro_run | output | 1 | Coprocessor run flag (1 = running, bus not granted) |
| copro_rst | output | 1 | One-clock coprocessor reset pulse |
| bank | output | BANK_W (9) | Bank window select |
| ram_we | output | 1 | Work RAM write strobe |
| ram_re | output | 1 | Work RAM read strobe |
| ram_addr | output | RAM_AW (13) | Work RAM byte address |
| ram_wdata | output | 8 | Work RAM write byte |
| ram_rdata | input | 8 | Work RAM read byte, one clock after `ram_re` |

## Verification
If the run flag is wrong, it shows on `copro_run` in the very next clock. It also shows up later as RAM writes being dropped or let through, which a later read-back reveals. A wrong stop time stamp, or a window counter that ages too early or too late, is visible only in bit 0 of a bus-request read. So reads are placed at exactly 1, 32 and 33 clocks after a halt. A bank bit that is lost or misrouted appears on `bank` one clock after the shifting write. A broken response register shows up as reordered data, data that changes during a stall, or a response with no matching read.

// File: rtl/copro_pkg.sv
package copro_pkg;
  localparam int unsigned HOST_AW = 24;

  localparam logic [HOST_AW-1:0] BUSREQ_LOC = 24'hA11100;
  localparam logic [HOST_AW-1:0] CRESET_LOC = 24'hA11200;
  localparam logic [HOST_AW-1:0] WRAM_MASK  = 24'hFF4000;
  localparam logic [HOST_AW-1:0] WRAM_BASE  = 24'hA00000;
  localparam logic [HOST_AW-1:0] BANK_MASK  = 24'hFF7F00;
  localparam logic [HOST_AW-1:0] BANK_BASE  = 24'hA06000;

  localparam logic [15:0] OPEN_BUS = 16'hFFFF;

  typedef struct packed {
    logic wram;
    logic bank;
    logic busreq;
    logic creset;
  } hit_t;

  typedef enum logic {
    SRC_HELD = 1'b0,
    SRC_WRAM = 1'b1
  } rsp_src_e;
endpackage

// File: rtl/copro_addr_decode.sv
module copro_addr_decode
  import copro_pkg::*;
(
  input  logic [HOST_AW-1:0] addr,
  output hit_t               hit
);
  always_comb begin
    hit.wram   = (addr & WRAM_MASK) == WRAM_BASE;
    hit.bank   = (addr & BANK_MASK) == BANK_BASE;
    hit.busreq = addr == BUSREQ_LOC;
    hit.creset = addr == CRESET_LOC;
  end
endmodule

// File: rtl/copro_busreq_ctrl.sv
module copro_busreq_ctrl #(
  parameter int unsigned WINDOW = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_busreq,
  input  logic wr_creset,
  input  logic wbit,
  output logic run,
  output logic busy,
  output logic rst_pulse
);
  localparam int unsigned CNT_W = $clog2(WINDOW + 1) + 1;
  localparam logic [CNT_W-1:0] WIN_LIM = CNT_W'(WINDOW);

  logic [CNT_W-1:0] cyc_q;
  logic [CNT_W-1:0] stamp_q;
  logic             aged_q;
  logic [CNT_W-1:0] elapsed;
  logic             stop_now;

  assign stop_now = wr_busreq && wbit && run;
  assign elapsed  = cyc_q - stamp_q;
  assign busy     = run || (!aged_q && (elapsed != '0) && (elapsed <= WIN_LIM));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= 1'b1;
      rst_pulse <= 1'b0;
      cyc_q     <= '0;
      stamp_q   <= '0;
      aged_q    <= 1'b1;
    end else begin
      cyc_q     <= cyc_q + 1'b1;
      rst_pulse <= wr_creset && !wbit;
      if (wr_busreq) run <= !wbit;
      if (stop_now) begin
        stamp_q <= cyc_q;
        aged_q  <= 1'b0;
      end else if (!aged_q && (elapsed > WIN_LIM)) begin
        aged_q  <= 1'b1;
      end
    end
  end

  assert_rst_pulse_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(wr_creset && !wbit));

  assert_busy_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_now) |-> (busy && !run));
endmodule

// File: rtl/copro_bank_shift.sv
module copro_bank_shift #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] bank
);
  for (genvar i = 0; i < W; i++) begin : g_stage
    logic nxt;
    if (i == W - 1) begin : g_top
      assign nxt = din;
    end else begin : g_mid
      assign nxt = bank[i+1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)        bank[i] <= 1'b0;
      else if (shift_en) bank[i] <= nxt;
    end
  end

  assert_bank_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shift_en) |-> (bank == {$past(din), $past(bank[W-1:1])}));

  assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(shift_en) |-> $stable(bank));
endmodule

// File: rtl/copro_bus_ctrl.sv
module copro_bus_ctrl
  import copro_pkg::*;
#(
  parameter int unsigned RAM_AW       = 13,
  parameter int unsigned BANK_W       = 9,
  parameter int unsigned GRANT_WINDOW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_word,
  input  logic [23:0]        req_addr,
  input  logic [15:0]        req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [15:0]        rsp_data,
  output logic               copro_run,
  output logic               copro_rst,
  output logic [BANK_W-1:0]  bank,
  output logic               ram_we,
  output logic               ram_re,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic [7:0]         ram_wdata,
  input  logic [7:0]         ram_rdata
);
  hit_t       hit;
  logic       acc, wr_acc, rd_acc;
  logic [7:0] wbyte;
  logic       busy;
  logic [7:0] status_byte;

  rsp_src_e   src_q;
  logic [15:0] held_q;
  logic       rsp_valid_q;

  copro_addr_decode u_dec (
    .addr (req_addr),
    .hit  (hit)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign rd_acc    = acc && !req_write;
  assign wbyte     = req_word ? req_wdata[15:8] : req_wdata[7:0];

  copro_busreq_ctrl #(.WINDOW(GRANT_WINDOW)) u_breq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_busreq (wr_acc && hit.busreq),
    .wr_creset (wr_acc && hit.creset),
    .wbit      (wbyte[0]),
    .run       (copro_run),
    .busy      (busy),
    .rst_pulse (copro_rst)
  );

  copro_bank_shift #(.W(BANK_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (wr_acc && hit.bank),
    .din      (req_wdata[0]),
    .bank     (bank)
  );

  assign ram_we    = wr_acc && hit.wram && !copro_run;
  assign ram_re    = rd_acc && hit.wram;
  assign ram_addr  = req_addr[RAM_AW-1:0];
  assign ram_wdata = wbyte;

  assign status_byte = {1'b1, 6'b0, busy};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      src_q       <= SRC_HELD;
      held_q      <= OPEN_BUS;
    end else if (rd_acc) begin
      rsp_valid_q <= 1'b1;
      src_q       <= hit.wram ? SRC_WRAM : SRC_HELD;
      held_q      <= hit.busreq ? {status_byte, status_byte} : OPEN_BUS;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = (src_q == SRC_WRAM) ? {ram_rdata, ram_rdata} : held_q;

  assert_ram_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (!copro_run && req_valid && req_write));

  assert_run_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_acc && hit.busreq) |-> (copro_run == !$past(wbyte[0])));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_write_no_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !rsp_valid) |=> !rsp_valid);
endmodule

// File: tb/copro_bus_ctrl_test.sv
`timescale 1ns/1ps
module copro_bus_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        copro_run;
  logic        copro_rst;
  logic [8:0]  bank;
  logic        ram_we;
  logic        ram_re;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;

  always #2.5 clk = ~clk;

  copro_bus_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .copro_run(copro_run), .copro_rst(copro_rst), .bank(bank),
    .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // work RAM model: one-clock read latency, output held between reads
  logic [7:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr[7:0]];
  end

  typedef struct {
    logic [15:0] d;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  int n_chk = 0;
  int n_fail = 0;
  bit bp = 1'b0;
  int bp_cnt = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic wd, input logic [23:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, input logic wd, input logic [15:0] e, input string tag);
    exp_t x;
    x.d = e; x.tag = tag;
    sbq.push_back(x);
    issue(1'b0, wd, a, 16'h0000);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // scoreboard monitor
  initial begin
    logic [15:0] held = '0;
    bit          held_v = 1'b0;
    exp_t        e;
    forever begin
      @(negedge clk);
      rsp_ready = bp ? ((bp_cnt % 3) == 0) : 1'b1;
      bp_cnt++;
      #2;
      if (held_v) chk("R10 stalled response stable", {15'b0, rsp_valid, rsp_data}, {15'b0, 1'b1, held});
      if (rsp_valid && rsp_ready) begin
        if (sbq.size() == 0) begin
          chk("R10 response without read", 32'd1, 32'd0);
        end else begin
          e = sbq.pop_front();
          chk(e.tag, {16'b0, rsp_data}, {16'b0, e.d});
        end
      end
      held_v = rsp_valid && !rsp_ready;
      held   = rsp_data;
    end
  end

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [8:0] bexp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 run after reset", {31'b0, copro_run}, 32'd1);
    chk("R9 bank after reset", {23'b0, bank}, 32'd0);
    chk("R9 reset pulse idle", {31'b0, copro_rst}, 32'd0);
    chk("R9 no response", {31'b0, rsp_valid}, 32'd0);

    rd(24'hA11100, 1'b0, 16'h8181, "R2 R3 status while running");
    issue(1'b1, 1'b0, 24'hA00010, 16'h005A);                  // dropped: running
    issue(1'b1, 1'b0, 24'hA11100, 16'h0001);                  // halt at T
    chk("R1 byte write halts", {31'b0, copro_run}, 32'd0);
    rd(24'hA11100, 1'b0, 16'h8181, "R3 busy at k=1");
    idle(30);
    rd(24'hA11100, 1'b1, 16'h8181, "R3 busy at k=32");
    rd(24'hA11100, 1'b0, 16'h8080, "R3 granted at k=33");

    rd(24'hA00010, 1'b1, 16'h0000, "R6 write while running dropped");
    issue(1'b1, 1'b0, 24'hA00010, 16'h005A);
    issue(1'b1, 1'b1, 24'hA00020, 16'hC311);
    issue(1'b1, 1'b0, 24'hA02033, 16'h0077);
    rd(24'hA00010, 1'b0, 16'h5A5A, "R7 byte read mirrored");
    rd(24'hA00020, 1'b1, 16'hC3C3, "R6 word write stores high byte");
    rd(24'hA00033, 1'b0, 16'h7777, "R6 address bits 12:0 only");

    issue(1'b1, 1'b0, 24'hA11100, 16'h0000);
    chk("R1 byte write restarts", {31'b0, copro_run}, 32'd1);
    issue(1'b1, 1'b0, 24'hA00010, 16'h00EE);
    rd(24'hA00010, 1'b0, 16'h5A5A, "R6 running blocks write");

    issue(1'b1, 1'b1, 24'hA11100, 16'h0100);
    chk("R1 word write uses high byte (halt)", {31'b0, copro_run}, 32'd0);
    issue(1'b1, 1'b1, 24'hA11100, 16'h00FF);
    chk("R1 word write uses high byte (run)", {31'b0, copro_run}, 32'd1);

    issue(1'b1, 1'b0, 24'hA11200, 16'h0000);
    chk("R4 pulse after clear bit", {31'b0, copro_rst}, 32'd1);
    @(posedge clk); #1;
    chk("R4 pulse lasts one clock", {31'b0, copro_rst}, 32'd0);
    issue(1'b1, 1'b0, 24'hA11200, 16'h0001);
    chk("R4 set bit gives no pulse", {31'b0, copro_rst}, 32'd0);
    issue(1'b1, 1'b1, 24'hA11200, 16'h00FF);
    chk("R4 word write tests bit 8", {31'b0, copro_rst}, 32'd1);
    issue(1'b1, 1'b1, 24'hA11200, 16'h0100);
    chk("R4 word bit 8 set no pulse", {31'b0, copro_rst}, 32'd0);

    bexp = '0;
    for (int i = 0; i < 9; i++) begin
      logic        b;
      logic [23:0] a;
      b = ((9'b101100111 >> i) & 9'd1) != 0;
      a = (i % 3 == 0) ? 24'hA06000 : ((i % 3 == 1) ? 24'hA06055 : 24'hA0E0AA);
      issue(1'b1, i[0], a, {7'b0, ~b, 7'b0, b});
      bexp = {b, bexp[8:1]};
      chk("R5 bank shift", {23'b0, bank}, {23'b0, bexp});
    end
    issue(1'b1, 1'b0, 24'hA07000, 16'h0001);
    chk("R5 non-matching write ignored", {23'b0, bank}, {23'b0, bexp});

    rd(24'hA04000, 1'b0, 16'hFFFF, "R8 sound window");
    rd(24'hA06000, 1'b1, 16'hFFFF, "R8 bank location");
    rd(24'hA11200, 1'b0, 16'hFFFF, "R8 reset location");
    rd(24'h000000, 1'b1, 16'hFFFF, "R8 outside area");

    bp = 1'b1;
    rd(24'hA11100, 1'b0, 16'h8181, "R10 order 1");
    rd(24'hA00010, 1'b0, 16'h5A5A, "R10 order 2");
    rd(24'hA00033, 1'b1, 16'h7777, "R10 order 3");
    rd(24'hA07FFF, 1'b0, 16'hFFFF, "R10 order 4");
    idle(8);
    bp = 1'b0;

    issue(1'b1, 1'b0, 24'hA11100, 16'h0001);
    idle(40);
    rd(24'hA11100, 1'b0, 16'h8080, "R3 granted long after halt");
    issue(1'b1, 1'b0, 24'hA11100, 16'h0001);
    rd(24'hA11100, 1'b0, 16'h8080, "R3 repeat halt keeps old stamp");

    idle(10);
    chk("R10 every read answered", sbq.size(), 32'd0);
    summary();
    $finish;
  end
endmodule